// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one DMA channel. Software loads a source address, a destination address and a byte count, picks an operand size (byte, word or long word) and a transfer mode, and then sets a start bit. The channel then moves operands over a simple bus master port. Each bus cycle is a request with address, direction and size, held until the bus returns a one-cycle done or error pulse. Each operand transfer updates the address registers and the byte count. When the count reaches zero the channel stops and reports completion. A bus error makes the channel stop and report a fault.

In dual-address mode an operand is a read from the source address and then a write of the same data to the destination address. In single-address mode an operand is one bus cycle. A direction bit chooses whether that cycle is a read at the source address or a write at the destination address, and the other address register is left alone. Operands are paced in one of two ways. The channel can request the bus whenever it is started, or it can wait for a level-sensitive external request input.

Register map (word index on `reg_addr`): 0 control, 1 status, 2 source address, 3 destination address, 4 byte count. Control bits are: [0] start, [1] external pacing, [2] single-address mode, [3] single-address direction (0 = read at source, 1 = write at destination), [5:4] size (0 byte, 1 word, 2 or 3 long word), [6] source increment enable, [7] destination increment enable. Status bits are: [0] done, [1] error, [2] active. The active bit is read-only. Writing a one to bit 0 or bit 1 clears that flag.

Top module: `dma_chan_seq`

## Requirements
- R1: With its increment enable set, an address register grows by 1, 2 or 4 (size code 0, 1, 2/3) after each of its bus cycles.
- R2: With its increment enable clear, an address register keeps its value across transfers.
- R3: Each operand that completes without error lowers the byte count by the operand's byte width. A count smaller than the width becomes zero.
- R4: When the count is zero, the channel sets the done flag (status bit 0), clears active (status bit 2) and makes no further bus requests.
- R5: A bus error sets the error flag (status bit 1) and clears active. The address register of the failing cycle still advances. The count is not lowered.
- R6: A start write is refused while done or error is set. Writing one to status bit 0 or bit 1 clears that flag.
- R7: With internal pacing, `bus_req` rises on the second clock edge after the clock edge that captures the start write.
- R8: With external pacing, an operand begins only on a clock edge where `ext_req` is high, the channel is active and it is between operands. Any `ext_req` activity while the channel is not started has no effect.
- R9: In dual-address mode, a read at the source address is always followed by a write of the read data to the destination address. No new request is accepted in between.
- R10: Clearing the start bit halts the channel after the operand in progress finishes. Active then clears, and done stays clear.
- R11: In single-address mode, each operand is one bus cycle. Direction 0 reads at the source address and direction 1 writes at the destination address. The unused address register is unchanged.
- R12: While `bus_req` is high and no done or error pulse has arrived, `bus_addr`, `bus_wr` and `bus_size` stay stable, including across both halves of a dual-address operand.
- R13: Control fields written while the channel is active apply from the next operand onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_req | input | 1 | External operand request, level sensitive |
| bus_req | output | 1 | Bus cycle request |
| bus_wr | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_size | output | 2 | Operand size code of the cycle |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, sampled with the done pulse |
| bus_ack | input | 1 | Cycle finished normally (one-cycle pulse) |
| bus_err | input | 1 | Cycle finished with error (one-cycle pulse) |

## Verification
The assertions rely on the bus side behaving in a fixed way. `bus_ack` and `bus_err` are single-cycle pulses. They appear only while `bus_req` is high, and never both together. `AW` and `CW` must not exceed the 32-bit register data path. The bench responder only ever raises a pulse after it has seen a pending request, and drops it on the next cycle. Register writes come from a single task that drives one write per clock. `ext_req` is driven only from test tasks, either as a one-clock pulse or as a held level.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } op_size_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;

  typedef struct packed {
    logic     dst_inc;
    logic     src_inc;
    op_size_e size;
    logic     one_dir;
    logic     one_addr;
    logic     ext_sel;
    logic     go;
  } ctrl_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_STAT = 3'd1;
  localparam logic [2:0] RA_SRC  = 3'd2;
  localparam logic [2:0] RA_DST  = 3'd3;
  localparam logic [2:0] RA_CNT  = 3'd4;

  function automatic logic [2:0] size_bytes(op_size_e s);
    case (s)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_WORD: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  input  logic          inc_en,
  input  logic [2:0]    step_bytes,
  output logic [AW-1:0] q
);

  logic          adv;
  logic          en;
  logic [AW-1:0] q_d;

  always_comb begin
    adv = step && inc_en;
    en  = load || adv;
    // hardware advance has priority over a software load in the same cycle
    q_d = adv ? (q + AW'(step_bytes)) : load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_d;
    end
  end

  // R1
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && inc_en) |=> (q - $past(q)) == AW'($past(step_bytes)));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(step && inc_en)) |=> $stable(q));

endmodule

// File: rtl/dma_byte_cnt.sv
module dma_byte_cnt #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  input  logic [2:0]    dec_bytes,
  output logic [CW-1:0] q,
  output logic          zero
);

  logic [CW-1:0] width;
  logic [CW-1:0] q_d;
  logic          en;

  always_comb begin
    width = CW'(dec_bytes);
    en    = load || dec;
    if (dec) begin
      q_d = (q <= width) ? '0 : (q - width);
    end else begin
      q_d = load_val;
    end
    zero = (q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      q <= q_d;
    end
  end

  // R3
  cnt_never_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> q <= $past(q));

  // R3
  cnt_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (q < $past(q)) || ($past(q) == '0));

endmodule

// File: rtl/dma_seq_ctl.sv
module dma_seq_ctl
  import dma_seq_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          go,
  input  logic          ext_sel,
  input  logic          ext_req,
  input  logic          one_addr,
  input  logic          one_dir,
  input  logic          cnt_zero,
  input  op_size_e      size_sel,
  input  logic          bus_ack,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_wr,
  output op_size_e      bus_size,
  output logic [DW-1:0] bus_wdata,
  output logic          idle,
  output logic          src_step,
  output logic          dst_step,
  output logic          cnt_dec,
  output logic          op_fail,
  output logic [2:0]    step_bytes
);

  phase_e        ph_q, ph_d;
  op_size_e      sz_q, sz_d;
  logic          one_q, one_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          launch;
  logic          cyc_end;
  logic          cap_en;
  logic          dat_en;

  always_comb begin
    launch  = (ph_q == PH_IDLE) && active && go && !cnt_zero && (!ext_sel || ext_req);
    cyc_end = (ph_q != PH_IDLE) && (bus_ack || bus_err);
    ph_d     = ph_q;
    sz_d     = size_sel;
    one_d    = one_addr;
    dat_d    = bus_rdata;
    cap_en   = 1'b0;
    dat_en   = 1'b0;
    src_step = 1'b0;
    dst_step = 1'b0;
    cnt_dec  = 1'b0;
    op_fail  = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (launch) begin
          cap_en = 1'b1;
          ph_d   = (one_addr && one_dir) ? PH_WRITE : PH_READ;
        end
      end
      PH_READ: begin
        if (cyc_end) begin
          src_step = 1'b1;
          if (bus_err) begin
            op_fail = 1'b1;
            ph_d    = PH_IDLE;
          end else if (one_q) begin
            cnt_dec = 1'b1;
            ph_d    = PH_IDLE;
          end else begin
            dat_en = 1'b1;
            ph_d   = PH_WRITE;
          end
        end
      end
      PH_WRITE: begin
        if (cyc_end) begin
          dst_step = 1'b1;
          ph_d     = PH_IDLE;
          if (bus_err) begin
            op_fail = 1'b1;
          end else begin
            cnt_dec = 1'b1;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
    end else begin
      ph_q <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sz_q  <= SZ_BYTE;
      one_q <= 1'b0;
    end else if (cap_en) begin
      sz_q  <= sz_d;
      one_q <= one_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
    end else if (dat_en) begin
      dat_q <= dat_d;
    end
  end

  always_comb begin
    bus_req    = (ph_q != PH_IDLE);
    bus_wr     = (ph_q == PH_WRITE);
    bus_size   = sz_q;
    bus_wdata  = dat_q;
    idle       = (ph_q == PH_IDLE);
    step_bytes = size_bytes(sz_q);
  end

  // R12
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !bus_err) |=> bus_req && $stable(bus_wr) && $stable(bus_size));

  // R9
  pair_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_ack && !one_q) |=> bus_req && bus_wr && $stable(bus_size));

  // R8
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_req) && $past(ext_sel)) |-> $past(ext_req) && $past(active));

  // R10
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(go) && $past(active));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 24,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ext_req,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [1:0]    bus_size,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  input  logic          bus_err
);

  localparam int unsigned RW = 32;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_core_n = rs_q[1];

  // register file
  ctrl_t         ctrl_q;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          act_q, act_d;
  logic          wr_ctrl, wr_stat, wr_src, wr_dst, wr_cnt;
  logic          start;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero;
  logic          seq_idle, src_step, dst_step, cnt_dec, op_fail;
  logic [2:0]    step_bytes;
  op_size_e      cyc_size;

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    wr_stat = reg_we && (reg_addr == RA_STAT);
    wr_src  = reg_we && (reg_addr == RA_SRC);
    wr_dst  = reg_we && (reg_addr == RA_DST);
    wr_cnt  = reg_we && (reg_addr == RA_CNT);
    start   = wr_ctrl && reg_wdata[0] && !act_q && !done_q && !err_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(reg_wdata[7:0]);
    end
  end

  always_comb begin
    done_d = done_q;
    err_d  = err_q;
    act_d  = act_q;
    if (wr_stat) begin
      if (reg_wdata[0]) done_d = 1'b0;
      if (reg_wdata[1]) err_d  = 1'b0;
    end
    if (op_fail) begin
      err_d = 1'b1;
      act_d = 1'b0;
    end else if (act_q && seq_idle && cnt_zero) begin
      done_d = 1'b1;
      act_d  = 1'b0;
    end else if (act_q && seq_idle && !ctrl_q.go) begin
      act_d = 1'b0;
    end else if (start) begin
      act_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      err_q  <= err_d;
      act_q  <= act_d;
    end
  end

  dma_addr_reg #(.AW(AW)) u_src (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load       (wr_src),
    .load_val   (reg_wdata[AW-1:0]),
    .step       (src_step),
    .inc_en     (ctrl_q.src_inc),
    .step_bytes (step_bytes),
    .q          (src_q)
  );

  dma_addr_reg #(.AW(AW)) u_dst (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load       (wr_dst),
    .load_val   (reg_wdata[AW-1:0]),
    .step       (dst_step),
    .inc_en     (ctrl_q.dst_inc),
    .step_bytes (step_bytes),
    .q          (dst_q)
  );

  dma_byte_cnt #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (wr_cnt),
    .load_val  (reg_wdata[CW-1:0]),
    .dec       (cnt_dec),
    .dec_bytes (step_bytes),
    .q         (cnt_q),
    .zero      (cnt_zero)
  );

  dma_seq_ctl #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .active     (act_q),
    .go         (ctrl_q.go),
    .ext_sel    (ctrl_q.ext_sel),
    .ext_req    (ext_req),
    .one_addr   (ctrl_q.one_addr),
    .one_dir    (ctrl_q.one_dir),
    .cnt_zero   (cnt_zero),
    .size_sel   (ctrl_q.size),
    .bus_ack    (bus_ack),
    .bus_err    (bus_err),
    .bus_rdata  (bus_rdata),
    .bus_req    (bus_req),
    .bus_wr     (bus_wr),
    .bus_size   (cyc_size),
    .bus_wdata  (bus_wdata),
    .idle       (seq_idle),
    .src_step   (src_step),
    .dst_step   (dst_step),
    .cnt_dec    (cnt_dec),
    .op_fail    (op_fail),
    .step_bytes (step_bytes)
  );

  always_comb begin
    bus_size = cyc_size;
    bus_addr = bus_wr ? dst_q : src_q;
    case (reg_addr)
      RA_CTRL: reg_rdata = RW'(ctrl_q);
      RA_STAT: reg_rdata = RW'({act_q, err_q, done_q});
      RA_SRC:  reg_rdata = RW'(src_q);
      RA_DST:  reg_rdata = RW'(dst_q);
      RA_CNT:  reg_rdata = RW'(cnt_q);
      default: reg_rdata = '0;
    endcase
  end

  // R4
  done_stops_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(done_q) |-> !act_q && !bus_req);

  // R5
  err_halts_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(err_q) |-> !act_q && !bus_req);

  // R6
  start_refused_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (done_q || err_q) |=> !$rose(act_q));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!act_q && !bus_req) |=> !bus_req);

  // R12
  addr_hold_bus_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_req && !bus_ack && !bus_err) |=> $stable(bus_addr));

endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
  import dma_seq_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_req = 1'b0;
  logic        bus_req, bus_wr;
  logic [1:0]  bus_size;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        bus_ack = 1'b0;
  logic        bus_err = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int lat = 1;
  logic        err_arm = 1'b0;
  logic [31:0] err_addr = '0;
  logic [31:0] lg_addr [64];
  logic [31:0] lg_wdata [64];
  logic        lg_wr [64];
  logic [1:0]  lg_size [64];
  int n_log = 0;

  always #2.5 clk = ~clk;

  assign bus_rdata = bus_addr ^ 32'h5A5A_0000;

  dma_chan_seq i_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_req(ext_req),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_size(bus_size), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err)
  );

  // bus responder
  initial begin
    int wcnt;
    wcnt = 0;
    forever begin
      @(negedge clk);
      if (bus_ack || bus_err) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
        wcnt = 0;
      end else if (bus_req) begin
        if (wcnt >= lat) begin
          if (n_log < 64) begin
            lg_addr[n_log]  = bus_addr;
            lg_wdata[n_log] = bus_wdata;
            lg_wr[n_log]    = bus_wr;
            lg_size[n_log]  = bus_size;
          end
          n_log++;
          if (err_arm && bus_addr == err_addr) bus_err = 1'b1;
          else bus_ack = 1'b1;
        end else begin
          wcnt++;
        end
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] mk(input logic go, input logic ext, input logic one,
                                     input logic dir, input logic [1:0] sz,
                                     input logic sinc, input logic dinc);
    return {24'd0, dinc, sinc, sz, dir, one, ext, go};
  endfunction

  task automatic chk_regs(input string rq, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] c, input logic [31:0] st);
    logic [31:0] v;
    rd(RA_SRC, v);  chk(rq, "src", v, s);
    rd(RA_DST, v);  chk(rq, "dst", v, d);
    rd(RA_CNT, v);  chk(rq, "count", v, c);
    rd(RA_STAT, v); chk(rq, "status", v, st);
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      rd(RA_STAT, s);
      if (!s[2]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_log(input int n);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      #0.5;
      if (n_log >= n) break;
    end
  endtask

  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    wr(RA_SRC, s); wr(RA_DST, d); wr(RA_CNT, c);
    n_log = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(RA_CTRL, v); chk("R4", "reset ctrl", v, 32'h0);
    rd(RA_STAT, v); chk("R4", "reset status", v, 32'h0);
    chk("R4", "reset bus_req", {31'd0, bus_req}, 32'h0);
  endtask

  // R1 R3 R4 R7 R9: dual word, internal pacing
  task automatic t_dual_word();
    lat = 1;
    setup(32'h100, 32'h200, 32'd8);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = RA_CTRL; reg_wdata = mk(1, 0, 0, 0, 2'd1, 1, 1);
    @(negedge clk);
    reg_we = 1'b0;
    chk("R7", "req one edge after start", {31'd0, bus_req}, 32'h0);
    @(negedge clk);
    chk("R7", "req two edges after start", {31'd0, bus_req}, 32'h1);
    wait_idle();
    chk("R9", "cycle count", n_log, 8);
    for (int i = 0; i < 4; i++) begin
      chk("R9", "read addr", lg_addr[2*i], 32'h100 + 2*i);
      chk("R9", "read dir", {31'd0, lg_wr[2*i]}, 32'h0);
      chk("R9", "write addr", lg_addr[2*i+1], 32'h200 + 2*i);
      chk("R9", "write data", lg_wdata[2*i+1], (32'h100 + 2*i) ^ 32'h5A5A_0000);
      chk("R1", "word size", {30'd0, lg_size[2*i]}, 32'd1);
    end
    chk_regs("R4", 32'h108, 32'h208, 32'd0, 32'h1);
  endtask

  // R6: start refused while done is set
  task automatic t_start_blocked();
    logic [31:0] v;
    setup(32'h100, 32'h200, 32'd4);
    wr(RA_CTRL, mk(1, 0, 0, 0, 2'd0, 1, 1));
    repeat (6) @(negedge clk);
    chk("R6", "no cycles while done set", n_log, 0);
    rd(RA_STAT, v); chk("R6", "still inactive", v, 32'h1);
    wr(RA_STAT, 32'h1);
    rd(RA_STAT, v); chk("R6", "done cleared", v, 32'h0);
  endtask

  // R1 R2 R3: long size, destination fixed, count saturates
  task automatic t_long_sat();
    setup(32'h1000, 32'h2000, 32'd5);
    wr(RA_CTRL, mk(1, 0, 0, 0, 2'd2, 1, 0));
    wait_idle();
    chk("R3", "operands for count 5", n_log, 4);
    chk("R1", "second read addr", lg_addr[2], 32'h1004);
    chk("R2", "second write addr", lg_addr[3], 32'h2000);
    chk_regs("R3", 32'h1008, 32'h2000, 32'd0, 32'h1);
    wr(RA_STAT, 32'h1);
  endtask

  // R5: bus error on second read
  task automatic t_bus_err();
    logic [31:0] v;
    setup(32'h300, 32'h400, 32'd4);
    err_arm = 1'b1; err_addr = 32'h301;
    wr(RA_CTRL, mk(1, 0, 0, 0, 2'd0, 1, 1));
    wait_idle();
    err_arm = 1'b0;
    chk("R5", "cycles before halt", n_log, 3);
    chk_regs("R5", 32'h302, 32'h401, 32'd3, 32'h2);
    wr(RA_CTRL, mk(1, 0, 0, 0, 2'd0, 1, 1));
    repeat (5) @(negedge clk);
    chk("R6", "no restart with error set", n_log, 3);
    wr(RA_STAT, 32'h2);
    rd(RA_STAT, v); chk("R6", "error cleared", v, 32'h0);
  endtask

  // R8: external pacing
  task automatic t_ext();
    setup(32'h40, 32'h80, 32'd4);
    wr(RA_CTRL, mk(0, 1, 0, 0, 2'd0, 1, 1));
    @(negedge clk); ext_req = 1'b1;
    repeat (4) @(negedge clk);
    ext_req = 1'b0;
    chk("R8", "request before start ignored", n_log, 0);
    wr(RA_CTRL, mk(1, 1, 0, 0, 2'd0, 1, 1));
    repeat (6) @(negedge clk);
    chk("R8", "no cycle without request", n_log, 0);
    ext_req = 1'b1;
    @(negedge clk);
    ext_req = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8", "one pulse one operand", n_log, 2);
    chk_regs("R8", 32'h41, 32'h81, 32'd3, 32'h4);
    ext_req = 1'b1;
    wait_idle();
    ext_req = 1'b0;
    chk("R8", "held request finishes", n_log, 8);
    chk_regs("R4", 32'h44, 32'h84, 32'd0, 32'h1);
    wr(RA_STAT, 32'h1);
  endtask

  // R9 R10: halt during a read still completes the write
  task automatic t_halt();
    lat = 3;
    setup(32'h700, 32'h800, 32'h100);
    wr(RA_CTRL, mk(1, 0, 0, 0, 2'd0, 1, 1));
    wait_log(1);
    wr(RA_CTRL, mk(0, 0, 0, 0, 2'd0, 1, 1));
    repeat (25) @(negedge clk);
    chk("R10", "cycles after halt", n_log, 2);
    chk("R9", "paired write done", {31'd0, lg_wr[1]}, 32'h1);
    chk_regs("R10", 32'h701, 32'h801, 32'hFF, 32'h0);
  endtask

  // R11: single-address read then write
  task automatic t_single();
    lat = 1;
    setup(32'h500, 32'h600, 32'd8);
    wr(RA_CTRL, mk(1, 0, 1, 0, 2'd2, 1, 1));
    wait_idle();
    chk("R11", "single read cycles", n_log, 2);
    chk("R11", "read addr 0", lg_addr[0], 32'h500);
    chk("R11", "read addr 1", lg_addr[1], 32'h504);
    chk("R11", "read dir", {31'd0, lg_wr[1]}, 32'h0);
    chk_regs("R11", 32'h508, 32'h600, 32'd0, 32'h1);
    wr(RA_STAT, 32'h1);
    setup(32'h900, 32'hA00, 32'd2);
    wr(RA_CTRL, mk(1, 0, 1, 1, 2'd0, 1, 1));
    wait_idle();
    chk("R11", "single write cycles", n_log, 2);
    chk("R11", "write addr 1", lg_addr[1], 32'hA01);
    chk("R11", "write dir", {31'd0, lg_wr[0]}, 32'h1);
    chk_regs("R11", 32'h900, 32'hA02, 32'd0, 32'h1);
    wr(RA_STAT, 32'h1);
  endtask

  // R12 R13: size change while active
  task automatic t_imm();
    lat = 3;
    setup(32'hB00, 32'hC00, 32'd16);
    wr(RA_CTRL, mk(1, 0, 0, 0, 2'd2, 1, 1));
    wait_log(1);
    wr(RA_CTRL, mk(1, 0, 0, 0, 2'd0, 1, 1));
    wait_idle();
    chk("R13", "total cycles", n_log, 26);
    chk("R12", "write half keeps long", {30'd0, lg_size[1]}, 32'd2);
    chk("R13", "next operand byte", {30'd0, lg_size[2]}, 32'd0);
    chk("R13", "next read addr", lg_addr[2], 32'hB04);
    chk_regs("R13", 32'hB10, 32'hC10, 32'd0, 32'h1);
    wr(RA_STAT, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_dual_word();
    t_start_blocked();
    t_long_sat();
    t_bus_err();
    t_ext();
    t_halt();
    t_single();
    t_imm();
    report();
  end

endmodule